// File: doc/BRIEF.md
# APB UART Register File with Byte FIFOs

This block is the bus-side half of a UART peripheral. A 32-bit APB slave decodes five word registers: a control/status word, a write-only baud divider word, a FIFO status word, a transmit data port and a receive data port. A bus write to the transmit port queues a byte in a transmit FIFO. A bus read of the receive port takes a byte out of a receive FIFO. Both FIFOs hold `DEPTH` bytes.

The serial shifter and the baud generator sit outside this block. They see the control bits and the divider value, and they move bytes through a handshake. The block raises `tx_avail` while a transmit byte waits and takes it on `tx_take`. It accepts a received byte on `rx_put`. Errors on either FIFO side are latched in sticky flags that software clears by writing 1. Two level-style interrupt requests report transmit space and receive data.

While the enable bit is low, the serial side is held in reset: its handshakes are ignored, but the bytes already stored in the FIFOs are kept.

Top module: `uart_apb_regs`

## Requirements
- R1: After reset, the control word reads 0 and the FIFO status reads 0x0200_0200, which means both FIFOs are empty and all flags are clear. Both interrupt requests are low and every core control output is low.
- R2: The control word at offset 0x0 stores enable in bit 0, TX interrupt enable in bit 2, RX interrupt enable in bit 3, CTS-enable in bit 4 and loopback in bit 8. Bit 1 reads the `core_busy` input. All other bits read 0. The stored bits drive `core_en`, `core_cts_en` and `core_loopback`.
- R3: A write to the divider at offset 0x4 sets `core_div_int` from bits 13:4 and `core_div_frac` from bits 3:0. A read of offset 0x4 returns 0.
- R4: A write to offset 0xC pushes bits 7:0 into the TX FIFO. The core receives the bytes on `tx_byte` in write order. The FIFO status word at offset 0x8 reports the TX level in bits 7:0 and TX empty in bit 9.
- R5: When the TX level equals `DEPTH`, TX full (bit 8) reads 1. A further bus push is discarded and sets TX overflow (bit 10).
- R6: A read of offset 0x10 pops the RX FIFO and returns the oldest byte in bits 7:0. The status word reports the RX level in bits 23:16, RX full in bit 24 and RX empty in bit 25.
- R7: A read of offset 0x10 while the RX FIFO is empty returns 0 and sets RX underflow (bit 27).
- R8: A core take while the TX FIFO is empty sets TX underflow (bit 11). A core put while the RX FIFO is full is discarded and sets RX overflow (bit 26).
- R9: The four error flags are sticky. Writing 1 to a flag's bit at offset 0x8 clears that flag. Writing 0 leaves it unchanged.
- R10: While enable is 0, `tx_take` and `rx_put` have no effect on the FIFOs or the flags. Bus pushes still work, and stored bytes are kept.
- R11: `irq_tx` equals TX interrupt enable AND NOT TX full. `irq_rx` equals RX interrupt enable AND NOT RX empty.
- R12: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 16 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| core_en | output | 1 | Serial core enable |
| core_cts_en | output | 1 | Pause transmit while CTS is low |
| core_loopback | output | 1 | Internal loopback select |
| core_div_int | output | 10 | Divider integer part |
| core_div_frac | output | 4 | Divider fractional part |
| core_busy | input | 1 | Transmitter still sending |
| tx_avail | output | 1 | TX FIFO holds a byte |
| tx_byte | output | 8 | Oldest TX byte |
| tx_take | input | 1 | Core takes the oldest TX byte |
| rx_put | input | 1 | Core offers a received byte |
| rx_byte | input | 8 | Received byte |
| irq_tx | output | 1 | TX space interrupt |
| irq_rx | output | 1 | RX data interrupt |

## Verification
The hardest states to reach are the ones with both FIFOs at their limits: a full transmit FIFO that still receives bus writes, and a full receive FIFO that still receives core puts. Both need the opposite side held still while the full side is pushed past `DEPTH`. The bench therefore keeps its transmit drain process switched off, pushes `DEPTH`+1 bytes, and checks the flags. It then releases the drain and compares the bytes in order against a scoreboard queue. The disabled state is reached by clearing the enable bit with bytes already stored. Core handshakes are then pulsed and the levels are read back through the status word.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam logic [15:0] OFS_CTRL  = 16'h0000;
  localparam logic [15:0] OFS_DIV   = 16'h0004;
  localparam logic [15:0] OFS_FSTAT = 16'h0008;
  localparam logic [15:0] OFS_TXD   = 16'h000C;
  localparam logic [15:0] OFS_RXD   = 16'h0010;

  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_BUSY = 1;
  localparam int CB_TXIE = 2;
  localparam int CB_RXIE = 3;
  localparam int CB_CTS  = 4;
  localparam int CB_LOOP = 8;

  // divider fields
  localparam int DIV_INT_W  = 10;
  localparam int DIV_FRAC_W = 4;

  // FIFO status bit positions (RX side at +16)
  localparam int FS_LVL   = 0;
  localparam int FS_FULL  = 8;
  localparam int FS_EMPTY = 9;
  localparam int FS_OVER  = 10;
  localparam int FS_UNDER = 11;
  localparam int FS_RXOFS = 16;

  typedef struct packed {
    logic loopback;
    logic cts_en;
    logic rx_ie;
    logic tx_ie;
    logic en;
  } ctrl_t;

  // flag index order inside the flag bank
  localparam int FL_TXOVER  = 0;
  localparam int FL_TXUNDER = 1;
  localparam int FL_RXOVER  = 2;
  localparam int FL_RXUNDER = 3;
  localparam int NFLAGS     = 4;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == LW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr_q];
  assign level   = cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = do_push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = do_pop  ? bump(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end
endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ctrl,
  input  logic                  wr_div,
  input  logic [31:0]           wdata,
  output ctrl_t                 ctrl,
  output logic [DIV_INT_W-1:0]  div_int,
  output logic [DIV_FRAC_W-1:0] div_frac
);
  ctrl_t ctrl_q, ctrl_d;
  logic [DIV_INT_W+DIV_FRAC_W-1:0] div_q, div_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en       = wdata[CB_EN];
      ctrl_d.tx_ie    = wdata[CB_TXIE];
      ctrl_d.rx_ie    = wdata[CB_RXIE];
      ctrl_d.cts_en   = wdata[CB_CTS];
      ctrl_d.loopback = wdata[CB_LOOP];
    end
    div_d = wr_div ? wdata[DIV_INT_W+DIV_FRAC_W-1:0] : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign div_int  = div_q[DIV_INT_W+DIV_FRAC_W-1:DIV_FRAC_W];
  assign div_frac = div_q[DIV_FRAC_W-1:0];
endmodule

// File: rtl/uart_flag_bank.sv
module uart_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, flag_d;

  // a set event in the same cycle as a clear wins
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag_q[i];
      if (clr[i]) flag_d[i] = 1'b0;
      if (set[i]) flag_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;
endmodule

// File: rtl/uart_apb_regs.sv
module uart_apb_regs
  import uart_regs_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [15:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  output logic        core_en,
  output logic        core_cts_en,
  output logic        core_loopback,
  output logic [9:0]  core_div_int,
  output logic [3:0]  core_div_frac,
  input  logic        core_busy,
  output logic        tx_avail,
  output logic [7:0]  tx_byte,
  input  logic        tx_take,
  input  logic        rx_put,
  input  logic [7:0]  rx_byte,
  output logic        irq_tx,
  output logic        irq_rx
);
  logic access, wr, rd;
  logic wr_ctrl, wr_div, wr_fstat, wr_txd, rd_rxd;
  ctrl_t ctrl;
  logic [LW-1:0] tx_level, rx_level;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0] rx_head;
  logic take_ok, put_ok;
  logic [NFLAGS-1:0] flag_set, flag_clr, flags;
  logic tx_over_q, rx_under_q;
  logic [31:0] ctrl_word, fstat_word;

  assign access   = psel && penable;
  assign wr       = access && pwrite;
  assign rd       = access && !pwrite;
  assign wr_ctrl  = wr && (paddr == OFS_CTRL);
  assign wr_div   = wr && (paddr == OFS_DIV);
  assign wr_fstat = wr && (paddr == OFS_FSTAT);
  assign wr_txd   = wr && (paddr == OFS_TXD);
  assign rd_rxd   = rd && (paddr == OFS_RXD);

  uart_ctrl_regs u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_div   (wr_div),
    .wdata    (pwdata),
    .ctrl     (ctrl),
    .div_int  (core_div_int),
    .div_frac (core_div_frac)
  );

  // serial-side handshakes only count while the UART is enabled
  assign take_ok = tx_take && ctrl.en;
  assign put_ok  = rx_put && ctrl.en;

  uart_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_txd),
    .wdata (pwdata[7:0]),
    .pop   (take_ok),
    .rdata (tx_byte),
    .level (tx_level),
    .full  (tx_full),
    .empty (tx_empty)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (put_ok),
    .wdata (rx_byte),
    .pop   (rd_rxd),
    .rdata (rx_head),
    .level (rx_level),
    .full  (rx_full),
    .empty (rx_empty)
  );

  always_comb begin
    flag_set             = '0;
    flag_set[FL_TXOVER]  = wr_txd && tx_full;
    flag_set[FL_TXUNDER] = take_ok && tx_empty;
    flag_set[FL_RXOVER]  = put_ok && rx_full;
    flag_set[FL_RXUNDER] = rd_rxd && rx_empty;
    flag_clr             = '0;
    if (wr_fstat) begin
      flag_clr[FL_TXOVER]  = pwdata[FS_OVER];
      flag_clr[FL_TXUNDER] = pwdata[FS_UNDER];
      flag_clr[FL_RXOVER]  = pwdata[FS_RXOFS + FS_OVER];
      flag_clr[FL_RXUNDER] = pwdata[FS_RXOFS + FS_UNDER];
    end
  end

  uart_flag_bank #(.N(NFLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .flags (flags)
  );

  assign tx_over_q  = flags[FL_TXOVER];
  assign rx_under_q = flags[FL_RXUNDER];

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[CB_EN]   = ctrl.en;
    ctrl_word[CB_BUSY] = core_busy;
    ctrl_word[CB_TXIE] = ctrl.tx_ie;
    ctrl_word[CB_RXIE] = ctrl.rx_ie;
    ctrl_word[CB_CTS]  = ctrl.cts_en;
    ctrl_word[CB_LOOP] = ctrl.loopback;

    fstat_word                              = '0;
    fstat_word[FS_LVL +: 8]                 = 8'(tx_level);
    fstat_word[FS_FULL]                     = tx_full;
    fstat_word[FS_EMPTY]                    = tx_empty;
    fstat_word[FS_OVER]                     = flags[FL_TXOVER];
    fstat_word[FS_UNDER]                    = flags[FL_TXUNDER];
    fstat_word[FS_RXOFS + FS_LVL +: 8]      = 8'(rx_level);
    fstat_word[FS_RXOFS + FS_FULL]          = rx_full;
    fstat_word[FS_RXOFS + FS_EMPTY]         = rx_empty;
    fstat_word[FS_RXOFS + FS_OVER]          = flags[FL_RXOVER];
    fstat_word[FS_RXOFS + FS_UNDER]         = flags[FL_RXUNDER];
  end

  always_comb begin
    prdata = '0;
    if (rd) begin
      unique case (paddr)
        OFS_CTRL:  prdata = ctrl_word;
        OFS_FSTAT: prdata = fstat_word;
        OFS_RXD:   prdata = rx_empty ? 32'h0 : {24'h0, rx_head};
        default:   prdata = '0;
      endcase
    end
  end

  assign pready        = 1'b1;
  assign pslverr       = 1'b0;
  assign core_en       = ctrl.en;
  assign core_cts_en   = ctrl.cts_en;
  assign core_loopback = ctrl.loopback;
  assign tx_avail      = !tx_empty;
  assign irq_tx        = ctrl.tx_ie && !tx_full;
  assign irq_rx        = ctrl.rx_ie && !rx_empty;
endmodule

// File: rtl/uart_apb_regs_chk.sv
module uart_apb_regs_chk #(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [15:0]   paddr,
  input logic [31:0]   pwdata,
  input logic [31:0]   prdata,
  input logic          pready,
  input logic          pslverr,
  input logic          core_en,
  input logic          irq_tx,
  input logic          irq_rx,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_over_q,
  input logic          rx_under_q
);
  logic acc, push_tx, pop_rx, clr_txover;
  assign acc        = psel && penable;
  assign push_tx    = acc && pwrite && (paddr == 16'h000C);
  assign pop_rx     = acc && !pwrite && (paddr == 16'h0010);
  assign clr_txover = acc && pwrite && (paddr == 16'h0008) && pwdata[10];

  p_bus_ok_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

  p_tx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH));

  p_tx_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_tx && (tx_level == LW'(DEPTH)) |=> tx_over_q);

  p_rx_under_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_rx && (rx_level == '0) |-> (prdata == 32'h0) ##1 rx_under_q);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_over_q && !clr_txover |=> tx_over_q);

  p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en && !acc |=> $stable(tx_level) && $stable(rx_level));

  p_irq_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> tx_level != LW'(DEPTH));

  p_irq_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rx_level != '0);
endmodule

bind uart_apb_regs uart_apb_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .psel       (psel),
  .penable    (penable),
  .pwrite     (pwrite),
  .paddr      (paddr),
  .pwdata     (pwdata),
  .prdata     (prdata),
  .pready     (pready),
  .pslverr    (pslverr),
  .core_en    (core_en),
  .irq_tx     (irq_tx),
  .irq_rx     (irq_rx),
  .tx_level   (tx_level),
  .rx_level   (rx_level),
  .tx_over_q  (tx_over_q),
  .rx_under_q (rx_under_q)
);

// File: tb/uart_apb_regs_test.sv
module uart_apb_regs_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        core_en, core_cts_en, core_loopback;
  logic [9:0]  core_div_int;
  logic [3:0]  core_div_frac;
  logic        core_busy = 1'b0;
  logic        tx_avail;
  logic [7:0]  tx_byte;
  logic        mon_pop = 1'b0, man_pop = 1'b0;
  logic        tx_take;
  logic        rx_put = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        irq_tx, irq_rx;

  int n_cmp = 0;
  int n_bad = 0;
  logic drain = 1'b0;
  logic [7:0] exp_tx [$];
  logic [7:0] exp_rx [$];
  logic [31:0] rd_val;

  assign tx_take = mon_pop | man_pop;

  always #2.5 clk = ~clk;

  uart_apb_regs #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .core_en(core_en), .core_cts_en(core_cts_en),
    .core_loopback(core_loopback), .core_div_int(core_div_int),
    .core_div_frac(core_div_frac), .core_busy(core_busy), .tx_avail(tx_avail),
    .tx_byte(tx_byte), .tx_take(tx_take), .rx_put(rx_put), .rx_byte(rx_byte),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fs(input int tl, input bit tov, input bit tun,
                                     input int rl, input bit rov, input bit run);
    logic [31:0] v = '0;
    v[7:0]   = 8'(tl);
    v[8]     = (tl == DEPTH);
    v[9]     = (tl == 0);
    v[10]    = tov;
    v[11]    = tun;
    v[23:16] = 8'(rl);
    v[24]    = (rl == DEPTH);
    v[25]    = (rl == 0);
    v[26]    = rov;
    v[27]    = run;
    return v;
  endfunction

  task automatic apb_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // driver: bus push with scoreboard entry when accepted
  task automatic tx_send(input logic [7:0] b, input bit accepted);
    if (accepted) exp_tx.push_back(b);
    apb_wr(16'h000C, {24'hA5A5A5, b});
  endtask

  task automatic core_put(input logic [7:0] b, input bit accepted);
    if (accepted) exp_rx.push_back(b);
    @(negedge clk);
    rx_put = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_put = 1'b0;
  endtask

  task automatic rx_read(input string req);
    logic [31:0] d;
    logic [7:0] e;
    apb_rd(16'h0010, d);
    e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 8'h00;
    check(req, d, {24'h0, e});
  endtask

  task automatic pulse_take();
    @(negedge clk); man_pop = 1'b1;
    @(negedge clk); man_pop = 1'b0;
  endtask

  // monitor: core-side consumer of the TX FIFO
  always @(negedge clk) begin
    if (drain && tx_avail) begin
      if (exp_tx.size() == 0) check("R4 unexpected tx byte", {24'h0, tx_byte}, 32'hFFFF_FFFF);
      else check("R4 tx order", {24'h0, tx_byte}, {24'h0, exp_tx.pop_front()});
      mon_pop = 1'b1;
    end else begin
      mon_pop = 1'b0;
    end
  end

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    apb_rd(16'h0000, rd_val); check("R1 ctrl", rd_val, 32'h0);
    apb_rd(16'h0008, rd_val); check("R1 fstat", rd_val, 32'h0200_0200);
    check("R1 irqs/core", {irq_tx, irq_rx, core_en, core_cts_en, core_loopback}, 0);
    check("R12 ready/err", {pready, pslverr}, 2'b10);

    // R2 control word
    apb_wr(16'h0000, 32'hFFFF_FFFF);
    apb_rd(16'h0000, rd_val); check("R2 ctrl all ones", rd_val, 32'h11D);
    core_busy = 1'b1;
    apb_rd(16'h0000, rd_val); check("R2 busy bit", rd_val, 32'h11F);
    core_busy = 1'b0;
    check("R2 core outputs", {core_en, core_cts_en, core_loopback}, 3'b111);
    check("R11 irq idle", {irq_tx, irq_rx}, 2'b10);
    apb_wr(16'h0000, 32'h0000_0009);
    check("R2 partial", {core_en, core_cts_en, core_loopback}, 3'b100);
    apb_wr(16'h0000, 32'h0000_000D);

    // R3 divider
    apb_wr(16'h0004, 32'h0000_3A57);
    check("R3 div", {core_div_int, core_div_frac}, {10'h3A5, 4'h7});
    apb_rd(16'h0004, rd_val); check("R3 read zero", rd_val, 32'h0);
    apb_wr(16'h0004, 32'hFFFF_FFFF);
    check("R3 div max", {core_div_int, core_div_frac}, {10'h3FF, 4'hF});

    // R4 R5 fill TX, overflow
    for (int i = 0; i < DEPTH; i++) tx_send(8'(8'h30 + i), 1'b1);
    apb_rd(16'h0008, rd_val); check("R5 tx full", rd_val, fs(DEPTH, 0, 0, 0, 0, 0));
    check("R11 irq_tx off when full", irq_tx, 1'b0);
    tx_send(8'hEE, 1'b0);
    apb_rd(16'h0008, rd_val); check("R5 tx overflow", rd_val, fs(DEPTH, 1, 0, 0, 0, 0));
    apb_wr(16'h0008, 32'h0);
    apb_rd(16'h0008, rd_val); check("R9 write 0 keeps", rd_val, fs(DEPTH, 1, 0, 0, 0, 0));
    apb_wr(16'h0008, 32'h0000_0400);
    apb_rd(16'h0008, rd_val); check("R9 write 1 clears", rd_val, fs(DEPTH, 0, 0, 0, 0, 0));
    drain = 1'b1;
    while (exp_tx.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    drain = 1'b0;
    apb_rd(16'h0008, rd_val); check("R4 tx drained", rd_val, fs(0, 0, 0, 0, 0, 0));

    // R8 TX underflow
    pulse_take();
    apb_rd(16'h0008, rd_val); check("R8 tx underflow", rd_val, fs(0, 0, 1, 0, 0, 0));
    apb_wr(16'h0008, 32'h0000_0800);

    // R6 R7 RX path
    core_put(8'h11, 1'b1); core_put(8'h22, 1'b1); core_put(8'h33, 1'b1);
    apb_rd(16'h0008, rd_val); check("R6 rx level", rd_val, fs(0, 0, 0, 3, 0, 0));
    check("R11 irq_rx", irq_rx, 1'b1);
    rx_read("R6 rx pop"); rx_read("R6 rx pop"); rx_read("R6 rx pop");
    check("R11 irq_rx idle", irq_rx, 1'b0);
    rx_read("R7 empty read zero");
    apb_rd(16'h0008, rd_val); check("R7 rx underflow", rd_val, fs(0, 0, 0, 0, 0, 1));
    apb_wr(16'h0008, 32'h0800_0000);

    // R8 RX overflow
    for (int i = 0; i < DEPTH; i++) core_put(8'(8'h80 + 3 * i), 1'b1);
    core_put(8'h5A, 1'b0);
    apb_rd(16'h0008, rd_val); check("R8 rx overflow", rd_val, fs(0, 0, 0, DEPTH, 1, 0));
    for (int i = 0; i < DEPTH; i++) rx_read("R6 rx order after full");
    apb_wr(16'h0008, 32'h0400_0000);
    apb_rd(16'h0008, rd_val); check("R9 rx clear", rd_val, fs(0, 0, 0, 0, 0, 0));

    // R10 disabled: handshakes ignored, data kept
    core_put(8'h44, 1'b1);
    apb_wr(16'h0000, 32'h0);
    tx_send(8'h77, 1'b1);
    core_put(8'h99, 1'b0);
    pulse_take();
    apb_rd(16'h0008, rd_val); check("R10 disabled hold", rd_val, fs(1, 0, 0, 1, 0, 0));
    check("R10 core_en low", core_en, 1'b0);
    apb_wr(16'h0000, 32'h1);
    drain = 1'b1;
    while (exp_tx.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    drain = 1'b0;
    rx_read("R10 rx kept");
    apb_rd(16'h0008, rd_val); check("R10 after reenable", rd_val, fs(0, 0, 0, 0, 0, 0));
    check("R12 ready/err end", {pready, pslverr}, 2'b10);

    report();
  end
endmodule